// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block connects a CPU register bus to a small nonvolatile byte array, which is modelled here as an internal register array. Software sees four byte-wide registers: the low address byte, the high address byte, a data byte and a control byte. A read is a single strobe. It loads the addressed byte into the data register and holds the CPU for a fixed number of cycles.

A write is guarded by a two-step sequence. Software first sets an arm bit, which stays open for only a few CPU cycles. The start bit must then be set while the arm bit is still high. An accepted start sets a busy flag and holds the CPU briefly. It also hands the programming interval to a timer in the calibrated-oscillator clock domain. When the timer expires, a done event passes back through a synchronizer. The byte is then committed and the busy flag drops, so software can poll it. While busy is set, read strobes and address updates are ignored. The byte that is stored is whatever the data register holds when programming completes.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, all four registers read zero and `cpu_stall` is low.
- R2: Writing control bit 2 (arm) makes bit 2 read one for exactly ARM_CYCLES CPU cycles. After that it clears itself with no further access.
- R3: A control write with bit 1 (start) set begins a write only if the arm bit was already high before that access. Otherwise busy stays zero and the stored byte is unchanged. An access that sets arm and start together does not begin a write.
- R4: Control bit 1 reads one from the start edge until programming completes. Programming lasts at least PROG_CYCLES oscillator cycles. After it completes, the byte at the current address equals the committed data.
- R5: An accepted write start raises `cpu_stall` for exactly WR_STALL CPU cycles.
- R6: A control write with bit 0 (read) set and no write busy loads the addressed byte into the data register on the same edge. Bit 0 always reads zero.
- R7: An accepted read raises `cpu_stall` for exactly RD_STALL CPU cycles.
- R8: A read strobe issued while a write is busy leaves the data register unchanged and does not raise `cpu_stall`.
- R9: Writes to either address register while a write is busy are ignored.
- R10: A data-register write during a busy write is accepted, and that new value is the byte committed at completion.
- R11: Register selects are 0 low address (address bits 7:0), 1 high address (address bits ADDR_W-1:8, upper bits read zero), 2 data and 3 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| osc_clk | input | 1 | Calibrated oscillator clock that times programming |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_stall | output | 1 | Holds the CPU after an accepted access |

## Verification
The bench builds the block with ADDR_W=9, a 512-byte array and a high address register that carries one bit. It shortens PROG_CYCLES to 300 so that many complete writes fit in one run, with the oscillator slower than the CPU clock. ARM_CYCLES=4, WR_STALL=2 and RD_STALL=4 are kept small. This puts the last edge at which the arm is still open within reach, along with the first edge after it closes and exact stall lengths. The shortened interval also makes it possible to check the busy window against the programmed cycle count in time units.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_RD  = 0;
  localparam int unsigned CTL_WR  = 1;
  localparam int unsigned CTL_ARM = 2;
endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/nvm_bit_sync.sv
module nvm_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int unsigned PROG_CYCLES = 26368,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic osc_rst_n,
  input  logic start_tgl,
  output logic done_tgl
);
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PROG_CYCLES - 1);

  logic             start_s;
  logic             start_prev_q;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             start_evt;

  nvm_bit_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk   (osc_clk),
    .rst_n (osc_rst_n),
    .d     (start_tgl),
    .q     (start_s)
  );

  assign start_evt = start_s ^ start_prev_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (start_evt) begin
      run_d = 1'b1;
      cnt_d = CNT_TOP;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d  = 1'b0;
        done_d = ~done_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      start_prev_q <= 1'b0;
      run_q        <= 1'b0;
      cnt_q        <= '0;
      done_q       <= 1'b0;
    end else begin
      start_prev_q <= start_s;
      run_q        <= run_d;
      cnt_q        <= cnt_d;
      done_q       <= done_d;
    end
  end

  assign done_tgl = done_q;

  // R4
  timer_range_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    cnt_q <= CNT_TOP);

  // R4
  timer_full_count_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $rose(run_q) |-> cnt_q == CNT_TOP);
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned PROG_CYCLES = 26368,
  parameter int unsigned ARM_CYCLES  = 4,
  parameter int unsigned RD_STALL    = 4,
  parameter int unsigned WR_STALL    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_stall
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned HI_W    = ADDR_W - 8;
  localparam int unsigned ARM_W   = $clog2(ARM_CYCLES + 1);
  localparam int unsigned STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int unsigned STALL_W = $clog2(STALL_MAX + 1);

  logic clk_rst_n, osc_rst_n;

  nvm_rst_sync #(.STAGES(2)) u_rst_cpu (
    .clk (clk), .arst_n (rst_n), .rst_n_o (clk_rst_n));
  nvm_rst_sync #(.STAGES(2)) u_rst_osc (
    .clk (osc_clk), .arst_n (rst_n), .rst_n_o (osc_rst_n));

  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [7:0]         data_q, data_d;
  logic               arm_q, arm_d;
  logic [ARM_W-1:0]   arm_cnt_q, arm_cnt_d;
  logic               busy_q, busy_d;
  logic [STALL_W-1:0] stall_q, stall_d;
  logic               req_tgl_q, req_tgl_d;
  logic               done_tgl, done_s, done_prev_q;
  logic               done_evt;
  logic [7:0]         mem [DEPTH];

  logic wr_ctrl, wr_start, rd_start;

  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_start = wr_ctrl && reg_wdata[CTL_WR] && arm_q && !busy_q;
  assign rd_start = wr_ctrl && reg_wdata[CTL_RD] && !busy_q && !wr_start;

  nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .osc_clk   (osc_clk),
    .osc_rst_n (osc_rst_n),
    .start_tgl (req_tgl_q),
    .done_tgl  (done_tgl)
  );

  nvm_bit_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (clk),
    .rst_n (clk_rst_n),
    .d     (done_tgl),
    .q     (done_s)
  );

  assign done_evt = done_s ^ done_prev_q;

  // next state
  always_comb begin
    addr_d    = addr_q;
    data_d    = data_q;
    arm_d     = arm_q;
    arm_cnt_d = arm_cnt_q;
    busy_d    = busy_q;
    stall_d   = stall_q;
    req_tgl_d = req_tgl_q;

    if (stall_q != '0) stall_d = stall_q - 1'b1;

    if (arm_q) begin
      if (arm_cnt_q == '0) arm_d = 1'b0;
      else                 arm_cnt_d = arm_cnt_q - 1'b1;
    end

    if (reg_wr && !busy_q && reg_sel == SEL_ADDR_LO)
      addr_d = {addr_q[ADDR_W-1:8], reg_wdata};
    if (reg_wr && !busy_q && reg_sel == SEL_ADDR_HI)
      addr_d = {reg_wdata[HI_W-1:0], addr_q[7:0]};
    if (reg_wr && reg_sel == SEL_DATA)
      data_d = reg_wdata;

    if (wr_ctrl && reg_wdata[CTL_ARM]) begin
      arm_d     = 1'b1;
      arm_cnt_d = ARM_W'(ARM_CYCLES - 1);
    end

    if (wr_start) begin
      busy_d    = 1'b1;
      arm_d     = 1'b0;
      req_tgl_d = ~req_tgl_q;
      stall_d   = STALL_W'(WR_STALL);
    end else if (rd_start) begin
      data_d  = mem[addr_q];
      stall_d = STALL_W'(RD_STALL);
    end

    if (done_evt && busy_q) busy_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge clk_rst_n) begin
    if (!clk_rst_n) begin
      addr_q      <= '0;
      data_q      <= '0;
      arm_q       <= 1'b0;
      arm_cnt_q   <= '0;
      busy_q      <= 1'b0;
      stall_q     <= '0;
      req_tgl_q   <= 1'b0;
      done_prev_q <= 1'b0;
    end else begin
      addr_q      <= addr_d;
      data_q      <= data_d;
      arm_q       <= arm_d;
      arm_cnt_q   <= arm_cnt_d;
      busy_q      <= busy_d;
      stall_q     <= stall_d;
      req_tgl_q   <= req_tgl_d;
      done_prev_q <= done_s;
    end
  end

  // array commit (nonvolatile contents: no reset)
  always_ff @(posedge clk) begin
    if (done_evt && busy_q) mem[addr_q] <= data_q;
  end

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR_LO: reg_rdata = addr_q[7:0];
      SEL_ADDR_HI: reg_rdata = 8'(addr_q >> 8);
      SEL_DATA:    reg_rdata = data_q;
      default:     reg_rdata = {5'b0, arm_q, busy_q, 1'b0};
    endcase
  end

  assign cpu_stall = (stall_q != '0);

  // R3
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!clk_rst_n)
    $rose(busy_q) |-> $past(arm_q));

  // R5
  start_stall_len_chk: assert property (@(posedge clk) disable iff (!clk_rst_n)
    $rose(busy_q) |-> stall_q == STALL_W'(WR_STALL));

  // R9
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!clk_rst_n)
    (busy_q && $past(busy_q)) |-> $stable(addr_q));

  // R8
  no_read_reload_chk: assert property (@(posedge clk) disable iff (!clk_rst_n)
    (busy_q && $past(busy_q)) |-> stall_q <= $past(stall_q));

  // R2
  arm_bounded_chk: assert property (@(posedge clk) disable iff (!clk_rst_n)
    arm_cnt_q <= ARM_W'(ARM_CYCLES - 1));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!clk_rst_n)
    stall_q <= STALL_W'(STALL_MAX));
endmodule

// File: tb/nvm_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_ctrl_tb;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned PROG   = 300;
  localparam int unsigned ARM    = 4;
  localparam int unsigned RDS    = 4;
  localparam int unsigned WRS    = 2;
  localparam real OSC_PER = 7.0;

  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic cpu_stall;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [1 << ADDR_W];
  bit         valid [1 << ADDR_W];

  always #2 clk = ~clk;
  always #(OSC_PER/2) osc_clk = ~osc_clk;

  nvm_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG), .ARM_CYCLES(ARM),
             .RD_STALL(RDS), .WR_STALL(WRS)) u_dut (
    .clk(clk), .osc_clk(osc_clk), .rst_n(rst_n), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall));

  function automatic logic [7:0] exp_ctrl(bit arm, bit busy);
    return {5'b0, arm, busy, 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [7:0] val);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel; #0.2; v = reg_rdata;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic set_addr(logic [ADDR_W-1:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, 8'(a >> 8));
  endtask

  task automatic wait_idle(output realtime dur);
    logic [7:0] c; realtime t0;
    t0 = $realtime;
    peek(2'd3, c);
    while (c[1]) begin @(negedge clk); peek(2'd3, c); end
    dur = $realtime - t0;
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, output logic [7:0] v, output int st);
    set_addr(a);
    bus_wr(2'd3, 8'h01);
    count_stall(st);
    peek(2'd2, v);
  endtask

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v; int st; realtime dur;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin peek(2'(s), v); check("R1 reg", v, 0); end
    check("R1 stall", cpu_stall, 0);

    // R11 address split
    set_addr(9'h1A5);
    peek(2'd0, v); check("R11 lo", v, 8'hA5);
    peek(2'd1, v); check("R11 hi", v, 8'h01);
    bus_wr(2'd1, 8'hFF);
    peek(2'd1, v); check("R11 hi upper zero", v, 8'h01);

    // R4 R5 good write, start on edge right after arm
    bus_wr(2'd2, 8'h3C);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    count_stall(st); check("R5 write stall", st, WRS);
    peek(2'd3, v); check("R4 busy", v, exp_ctrl(0, 1));
    wait_idle(dur);
    checks++;
    if (dur < PROG*OSC_PER - 2*4.0 || dur > PROG*OSC_PER + 150.0) begin
      errors++; $display("FAIL R4 busy time actual=%0t expected=%0t", dur, PROG*OSC_PER);
    end
    model[9'h1A5] = 8'h3C; valid[9'h1A5] = 1;

    // R6 R7 read back
    do_read(9'h1A5, v, st);
    check("R7 read stall", st, RDS);
    check("R6 read data", v, 8'h3C);
    peek(2'd3, v); check("R6 rd bit zero", v, 0);

    // R2 arm expiry; R3 late start rejected
    bus_wr(2'd2, 8'h77);
    bus_wr(2'd3, 8'h04);
    peek(2'd3, v); check("R2 arm set", v, exp_ctrl(1, 0));
    repeat (ARM - 1) @(negedge clk);
    peek(2'd3, v); check("R2 arm last cycle", v, exp_ctrl(1, 0));
    @(negedge clk);
    peek(2'd3, v); check("R2 arm cleared", v, exp_ctrl(0, 0));
    bus_wr(2'd3, 8'h02);
    check("R3 no stall", cpu_stall, 0);
    peek(2'd3, v); check("R3 not busy", v, 0);
    repeat (PROG*2) @(negedge clk);
    do_read(9'h1A5, v, st); check("R3 byte kept", v, 8'h3C);

    // R3 arm and start in one access
    bus_wr(2'd2, 8'h55);
    bus_wr(2'd3, 8'h06);
    peek(2'd3, v); check("R3 same access", v, exp_ctrl(1, 0));
    repeat (ARM + 1) @(negedge clk);

    // R3 start on last open edge accepted; R8 R9 R10 during busy
    set_addr(9'h0F0);
    bus_wr(2'd2, 8'h11);
    bus_wr(2'd3, 8'h04);
    repeat (ARM - 1) @(negedge clk);
    bus_wr(2'd3, 8'h02);
    peek(2'd3, v); check("R3 last edge accepted", v, exp_ctrl(0, 1));
    repeat (WRS) @(negedge clk);
    bus_wr(2'd0, 8'h22);
    peek(2'd0, v); check("R9 addr lo held", v, 8'hF0);
    bus_wr(2'd1, 8'h01);
    peek(2'd1, v); check("R9 addr hi held", v, 8'h00);
    bus_wr(2'd3, 8'h01);
    check("R8 no stall", cpu_stall, 0);
    peek(2'd2, v); check("R8 data held", v, 8'h11);
    bus_wr(2'd2, 8'h99);
    peek(2'd2, v); check("R10 data accepted", v, 8'h99);
    wait_idle(dur);
    do_read(9'h0F0, v, st); check("R10 committed", v, 8'h99);
    model[9'h0F0] = 8'h99; valid[9'h0F0] = 1;

    // R4 random back-to-back writes after polling
    for (int i = 0; i < 8; i++) begin
      logic [ADDR_W-1:0] a; logic [7:0] d;
      a = ADDR_W'($urandom); d = 8'($urandom);
      wait_idle(dur);
      set_addr(a);
      bus_wr(2'd2, d);
      bus_wr(2'd3, 8'h04);
      bus_wr(2'd3, 8'h02);
      model[a] = d; valid[a] = 1;
    end
    wait_idle(dur);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      if (valid[a]) begin
        do_read(ADDR_W'(a), v, st);
        check("R4 random readback", v, model[a]);
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule